// File: doc/BRIEF.md
# Cache Victim Way Selector with Lockdown

This block picks the way a four-way cache replaces when a linefill allocates into a set. The cache presents an allocate request together with the valid bits of the addressed set. One cycle later the block returns a way index with a valid strobe. If every way is locked it returns a no-allocate flag instead, and the access is then handled as uncached.

A held control input selects the replacement policy. When it is high, a single global pointer rotates through the ways (round-robin). When it is low, a free-running 8-bit LFSR supplies the starting way (pseudo-random). Under either policy, an invalid way that is not locked is taken before the policy is consulted. A lockdown mask register, written through a load strobe, removes ways from allocation. Software uses it to pin cache contents or to limit cache pollution. Only allocation reads the mask. Tag lookup is outside this block and is not affected by it.

Top module: `victim_sel`

## Requirements
- R1: After reset the outputs `way_valid_o` and `no_alloc_o` are low, the round-robin pointer is 0, the lockdown mask is 0 (all ways allocatable) and the LFSR holds 8'hA5.
- R2: When `lock_we_i` is high at a clock edge, `lock_i` is loaded into the lockdown mask, where bit n high locks way n. A request sampled at that same edge still uses the previous mask.
- R3: A request sampled at a clock edge is answered at the next edge. `way_valid_o` and `no_alloc_o` are high for exactly the one cycle after a request cycle. Both are low after a cycle with no request.
- R4: If any way has `valid_i` bit n low and lock bit n low, `way_o` is the lowest such n, in both policies.
- R5: With `rr_mode_i` high and no unlocked invalid way, `way_o` is the first unlocked way found counting up from the pointer with wrap-around. The pointer then becomes that way plus one, modulo 4.
- R6: The pointer changes only on an allocation made by the round-robin policy. Requests served by the invalid-way preference, by the pseudo-random policy, or answered with no-allocate leave it unchanged.
- R7: With `rr_mode_i` low and no unlocked invalid way, `way_o` is the first unlocked way found counting up from LFSR bits [1:0] with wrap-around. The LFSR value used is the one held at the request edge.
- R8: The LFSR steps on every clock edge out of reset as next = {q[6:0], q[7]^q[5]^q[4]^q[3]}, and it is never zero.
- R9: If all four lock bits are set, a request yields `no_alloc_o` high and `way_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rr_mode_i | input | 1 | Policy select: 1 round-robin, 0 pseudo-random |
| lock_we_i | input | 1 | Load strobe for the lockdown mask |
| lock_i | input | 4 | New lockdown mask, bit n locks way n |
| alloc_req_i | input | 1 | Linefill allocate request |
| valid_i | input | 4 | Valid bits of the addressed set |
| way_o | output | 2 | Chosen victim way |
| way_valid_o | output | 1 | Victim strobe, one cycle after the request |
| no_alloc_o | output | 1 | All ways locked; treat the access as uncached |

## Verification
The hardest case to reach from the ports is a pseudo-random choice that lands on a locked way and has to wrap past the top way. Whether that happens depends on the LFSR phase at the moment of the request, and the phase cannot be observed directly. The bench keeps its own copy of the LFSR from the reset edge and sweeps every lock mask against every valid pattern in both policies. Because the phase keeps moving, each mask meets several starting ways. The bench also tracks the pointer across the whole sweep, so skips and wrap-around are checked against the history of allocations, and a directed case loads the mask in the same cycle as a request.

// File: rtl/victim_pkg.sv
package victim_pkg;
  localparam int unsigned NUM_WAYS  = 4;
  localparam int unsigned WAY_W     = $clog2(NUM_WAYS);
  localparam int unsigned LFSR_W    = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'hA5;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;  // bits 7,5,4,3
endpackage

// File: rtl/vs_lfsr.sv
module vs_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= {q[W-2:0], ^(q & TAPS)};
  end
  assign q_o = q;
endmodule

// File: rtl/vs_pick.sv
// First set bit of mask_i at or above start_i, wrapping.
module vs_pick #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] start_i,
  input  logic [N-1:0] mask_i,
  output logic [W-1:0] idx_o,
  output logic         hit_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = (int'(start_i) + k) % N;
      if (mask_i[j]) begin
        hit_o = 1'b1;
        idx_o = W'(j);
      end
    end
  end
endmodule

// File: rtl/victim_sel.sv
module victim_sel
  import victim_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rr_mode_i,
  input  logic                lock_we_i,
  input  logic [NUM_WAYS-1:0] lock_i,
  input  logic                alloc_req_i,
  input  logic [NUM_WAYS-1:0] valid_i,
  output logic [WAY_W-1:0]    way_o,
  output logic                way_valid_o,
  output logic                no_alloc_o
);
  logic [NUM_WAYS-1:0] lock_q;
  logic [WAY_W-1:0]    ptr_q;
  logic [LFSR_W-1:0]   lfsr_q;

  logic [NUM_WAYS-1:0] free_ways, inval_free;
  logic [WAY_W-1:0]    inv_idx, pol_idx, pol_start;
  logic                inv_hit, pol_hit;

  vs_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .q_o   (lfsr_q)
  );

  assign free_ways  = ~lock_q;
  assign inval_free = ~valid_i & free_ways;
  assign pol_start  = rr_mode_i ? ptr_q : lfsr_q[WAY_W-1:0];

  vs_pick #(.N(NUM_WAYS), .W(WAY_W)) u_pick_inv (
    .start_i('0),
    .mask_i (inval_free),
    .idx_o  (inv_idx),
    .hit_o  (inv_hit)
  );

  vs_pick #(.N(NUM_WAYS), .W(WAY_W)) u_pick_pol (
    .start_i(pol_start),
    .mask_i (free_ways),
    .idx_o  (pol_idx),
    .hit_o  (pol_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= '0;
    else if (lock_we_i) lock_q <= lock_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      way_o       <= '0;
      way_valid_o <= 1'b0;
      no_alloc_o  <= 1'b0;
    end else begin
      way_valid_o <= 1'b0;
      no_alloc_o  <= 1'b0;
      if (alloc_req_i) begin
        if (!pol_hit) begin
          no_alloc_o <= 1'b1;
        end else begin
          way_valid_o <= 1'b1;
          way_o       <= inv_hit ? inv_idx : pol_idx;
          if (!inv_hit && rr_mode_i) ptr_q <= pol_idx + WAY_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/victim_sel_chk.sv
module victim_sel_chk
  import victim_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rr_mode_i,
  input logic                alloc_req_i,
  input logic [WAY_W-1:0]    way_o,
  input logic                way_valid_o,
  input logic                no_alloc_o,
  input logic [NUM_WAYS-1:0] lock_q,
  input logic [WAY_W-1:0]    ptr_q,
  input logic [LFSR_W-1:0]   lfsr_q
);
  assert_resp_after_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (way_valid_o || no_alloc_o) |-> $past(alloc_req_i));
  assert_one_outcome_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(way_valid_o && no_alloc_o));
  assert_req_answered_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_req_i |=> (way_valid_o || no_alloc_o));
  assert_no_locked_victim_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    way_valid_o |-> ((($past(lock_q)) >> way_o) & 4'd1) == 4'd0);
  assert_no_alloc_all_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_alloc_o |-> $past(lock_q) == 4'hF);
  assert_ptr_moves_on_rr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(alloc_req_i && rr_mode_i) |-> $stable(ptr_q));
  assert_lfsr_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
endmodule

bind victim_sel victim_sel_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rr_mode_i  (rr_mode_i),
  .alloc_req_i(alloc_req_i),
  .way_o      (way_o),
  .way_valid_o(way_valid_o),
  .no_alloc_o (no_alloc_o),
  .lock_q     (lock_q),
  .ptr_q      (ptr_q),
  .lfsr_q     (lfsr_q)
);

// File: tb/victim_sel_tb.sv
`timescale 1ns/1ps
module victim_sel_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rr_mode_i = 1'b0;
  logic       lock_we_i = 1'b0;
  logic [3:0] lock_i = '0;
  logic       alloc_req_i = 1'b0;
  logic [3:0] valid_i = '0;
  logic [1:0] way_o;
  logic       way_valid_o, no_alloc_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_lfsr;
  logic [1:0] m_ptr;
  logic [3:0] m_lock;

  always #5 clk_i = ~clk_i;

  victim_sel u_dut (.*);

  // R8 model: steps every edge out of reset
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_lfsr <= 8'hA5;
    else         m_lfsr <= {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
  end

  function automatic logic [1:0] first_from(input logic [1:0] s, input logic [3:0] m);
    logic [1:0] r = 2'd0;
    bit f = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] j = s + 2'(k);
      if (!f && m[j]) begin f = 1'b1; r = j; end
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one request cycle; lock write optional in the same cycle
  task automatic apply(input bit mode, input logic [3:0] v, input bit we, input logic [3:0] lk);
    logic [3:0] free, invf;
    logic [1:0] ew;
    bit ev, en;
    string tag;
    rr_mode_i = mode; valid_i = v; alloc_req_i = 1'b1;
    lock_we_i = we; lock_i = lk;
    free = ~m_lock; invf = ~v & free;
    ev = 1'b0; en = 1'b0; ew = 2'd0;
    if (free == 4'd0) begin
      en = 1'b1; tag = "R9";
    end else if (invf != 4'd0) begin
      ev = 1'b1; ew = first_from(2'd0, invf); tag = "R4";
    end else if (mode) begin
      ev = 1'b1; ew = first_from(m_ptr, free); m_ptr = ew + 2'd1; tag = "R5";
    end else begin
      ev = 1'b1; ew = first_from(m_lfsr[1:0], free); tag = "R7";
    end
    if (we) m_lock = lk;
    @(posedge clk_i); @(negedge clk_i);
    alloc_req_i = 1'b0; lock_we_i = 1'b0;
    check({tag, " way_valid"}, way_valid_o, ev);
    check({tag, " no_alloc"}, no_alloc_o, en);
    if (ev) check({tag, " way"}, way_o, ew);
  endtask

  task automatic write_lock(input logic [3:0] lk);
    lock_we_i = 1'b1; lock_i = lk; alloc_req_i = 1'b0;
    m_lock = lk;
    @(posedge clk_i); @(negedge clk_i);
    lock_we_i = 1'b0;
    check("R3 idle way_valid", way_valid_o, 0);
    check("R3 idle no_alloc", no_alloc_o, 0);
  endtask

  initial begin
    m_ptr = 2'd0; m_lock = 4'd0;
    repeat (3) @(negedge clk_i);
    check("R1 way_valid", way_valid_o, 0);
    check("R1 no_alloc", no_alloc_o, 0);
    rst_ni = 1'b1;
    // R1: pointer and mask start at zero
    apply(1'b1, 4'hF, 1'b0, 4'h0);
    check("R1 first rr way", way_o, 0);
    // R2: same-cycle write uses the old mask, the next request sees all locked
    apply(1'b1, 4'hF, 1'b1, 4'hF);
    apply(1'b1, 4'hF, 1'b0, 4'h0);
    // R6: invalid-way fills and no-allocate leave the pointer alone
    write_lock(4'h0);
    apply(1'b1, 4'hB, 1'b0, 4'h0);
    apply(1'b0, 4'hF, 1'b0, 4'h0);
    apply(1'b1, 4'hF, 1'b0, 4'h0);
    // exhaustive sweep
    for (int md = 0; md < 2; md++)
      for (int lk = 0; lk < 16; lk++) begin
        write_lock(4'(lk));
        for (int v = 0; v < 16; v++) begin
          apply(md[0], 4'(v), 1'b0, 4'h0);
          if (v[0]) apply(md[0], 4'hF, 1'b0, 4'h0);
        end
      end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule